// File: doc/BRIEF.md
# Three-Cell Pack Protection Sequencer

This block decides, once per clock, whether a three-cell series pack may accept charge and whether it may deliver current. It works purely on digital flags: for every cell it receives four comparator results (above the overcharge trip level, above the overcharge recovery level, below the overdischarge trip level, at or above the overdischarge recovery level). It also receives pack-wide flags for a charger being attached, a load being attached and an overcurrent trip. An external inhibit line and an overdischarge-inhibit line complete the inputs. The outputs are a charge enable, a discharge enable, a power-down indication and one bleed (cell balancing) output per cell.

Every input passes through a two-flop synchroniser. A prescaler divides the clock into a slow tick. Three hold timers count ticks while their fault condition persists, each against its own limit, and restart when the condition drops or the state changes. A state machine with eight states sits on top of the timers: START, NORMAL, OVCHG (overcharge), OVDSG (overdischarge), BOTH (overcharge and overdischarge together), OVCUR (overcurrent), PDOWN (power-down) and ZEROV (dead-cell charging).

Transitions: START goes to NORMAL when all cells clear the overdischarge recovery level, or to ZEROV when a charger is seen. NORMAL goes to OVCUR, BOTH, OVDSG or OVCHG on timer expiry, in that priority. OVCHG goes to BOTH on overdischarge expiry, or back to NORMAL on recovery or on a load. BOTH goes to OVDSG when the charger leaves or the latched cells recover, and goes to OVCHG when all cells clear overdischarge. OVDSG goes to BOTH, NORMAL, ZEROV or PDOWN. OVCUR returns to NORMAL when the trip flag drops. PDOWN goes to NORMAL or ZEROV when a charger appears. ZEROV goes to NORMAL on recovery, or back to PDOWN when the charger leaves.

Top module: `cellguard_ctrl`

## Requirements
- R1: During reset all outputs are low. After reset the block holds both enables low (START) until every cell reports overdischarge recovery, which gives NORMAL, or until a charger is seen, which gives charge enable high and discharge enable low.
- R2: In NORMAL, with no inhibit, charge enable and discharge enable are both high and the bleed outputs are all low.
- R3: When any cell stays above its overcharge trip level for OVC_TICKS ticks, charge enable drops and discharge enable stays high. A dropout of the condition before expiry restarts the count.
- R4: Overcharge ends, and charge enable returns, once every latched cell falls to or below its overcharge recovery level. While a latched cell is still above recovery, charge enable stays low.
- R5: In overcharge, a load flag ends the overcharge even if a latched cell is still above its recovery level.
- R6: A bleed output is high only for a cell latched in overcharge that is still above its recovery level. All other bleed outputs are low, and no bleed output is high while charge enable is high.
- R7: When any cell stays below its overdischarge trip level for OVD_TICKS ticks, discharge enable drops and charge enable stays high. If the load flag is then low, the block enters power-down, with both enables and all bleed outputs low.
- R8: Power-down is left only on a synchronised charger flag. The block enters dead-cell charging (charge enable high, discharge enable low) if some cell is below recovery, and NORMAL once all cells reach recovery.
- R9: Overcharge and overdischarge can hold together, with both enables low. Removing the charger then drops the overcharge part (charge enable high, bleed low) and keeps discharge enable low.
- R10: A high inhibit input forces both enables low within three clocks, outside power-down. Returning it low restores the outputs of the current state. The inhibit never influences any state transition, so power-down still exits on a charger while the inhibit is high.
- R11: While the overdischarge-inhibit input is high, overdischarge is never detected and discharge enable stays high.
- R12: An overcurrent flag held for OCP_TICKS ticks in NORMAL drops both enables. They return when the flag goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_ovc_det | input | NCELL | Cell above overcharge trip level |
| cell_ovc_hold | input | NCELL | Cell above overcharge recovery level |
| cell_ovd_det | input | NCELL | Cell below overdischarge trip level |
| cell_ovd_clr | input | NCELL | Cell at or above overdischarge recovery level |
| chg_seen | input | 1 | Charger attached |
| load_seen | input | 1 | Load attached / discharge started |
| ocur_trip | input | 1 | Overcurrent comparator tripped |
| ctl_inhibit | input | 1 | High: forbid charge and discharge |
| od_inhibit | input | 1 | High: suppress overdischarge detection |
| chg_en | output | 1 | Charge path enable |
| dsg_en | output | 1 | Discharge path enable |
| pwr_down | output | 1 | Power-down state indication |
| bleed | output | NCELL | Per-cell balancing drive |

## Verification
The assertions assume that the inputs are ordinary level flags with no timing relation to the clock beyond what the synchroniser absorbs. They also assume consistent flag sets per cell: a cell above its trip level is also above its recovery level, and a cell below the overdischarge trip level does not report recovery. The stimulus changes inputs only on the falling clock edge. It always drives consistent flag sets and holds each setting for several ticks, so that every timer expiry and every restart falls at a cycle the reference model predicts.

// File: rtl/cg_pkg.sv
package cg_pkg;
    typedef enum logic [2:0] {
        CG_START  = 3'd0,
        CG_NORMAL = 3'd1,
        CG_OVCHG  = 3'd2,
        CG_OVDSG  = 3'd3,
        CG_BOTH   = 3'd4,
        CG_OVCUR  = 3'd5,
        CG_PDOWN  = 3'd6,
        CG_ZEROV  = 3'd7
    } cg_state_e;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign d_out = sync_q;
endmodule

// File: rtl/cg_tick_gen.sv
module cg_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/cg_hold_timer.sv
module cg_hold_timer #(
    parameter int LIMIT = 40,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cond,
    input  logic          restart,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!cond || restart) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/cellguard_ctrl.sv
module cellguard_ctrl
    import cg_pkg::*;
#(
    parameter int NCELL     = 3,
    parameter int TICK_DIV  = 200000,
    parameter int OVC_TICKS = 1000,
    parameter int OVD_TICKS = 40,
    parameter int OCP_TICKS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCELL-1:0] cell_ovc_det,
    input  logic [NCELL-1:0] cell_ovc_hold,
    input  logic [NCELL-1:0] cell_ovd_det,
    input  logic [NCELL-1:0] cell_ovd_clr,
    input  logic             chg_seen,
    input  logic             load_seen,
    input  logic             ocur_trip,
    input  logic             ctl_inhibit,
    input  logic             od_inhibit,
    output logic             chg_en,
    output logic             dsg_en,
    output logic             pwr_down,
    output logic [NCELL-1:0] bleed
);
    localparam int SW    = 4 * NCELL + 5;
    localparam int OVC_W = $clog2(OVC_TICKS + 1);
    localparam int OVD_W = $clog2(OVD_TICKS + 1);
    localparam int OCP_W = $clog2(OCP_TICKS + 1);

    // synchronised inputs
    logic [SW-1:0]    raw_vec;
    logic [SW-1:0]    sync_vec;
    logic [NCELL-1:0] s_ovc_det, s_ovc_hold, s_ovd_det, s_ovd_clr;
    logic             sync_chg, s_load, s_ocur, s_ctl, s_odinh;

    assign raw_vec = {cell_ovc_det, cell_ovc_hold, cell_ovd_det, cell_ovd_clr,
                      chg_seen, load_seen, ocur_trip, ctl_inhibit, od_inhibit};

    cg_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_vec),
        .d_out (sync_vec)
    );

    assign {s_ovc_det, s_ovc_hold, s_ovd_det, s_ovd_clr,
            sync_chg, s_load, s_ocur, s_ctl, s_odinh} = sync_vec;

    // tick and hold timers
    logic tick;
    cg_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    cg_state_e        state_q, state_d;
    logic [NCELL-1:0] ocf_q, ocf_d, ocf_kept;
    logic             st_change;
    logic             ovc_cond, ovd_cond, all_clr;
    logic [OVC_W-1:0] ovc_cnt;
    logic [OVD_W-1:0] ovd_cnt;
    logic [OCP_W-1:0] ocp_cnt;
    logic             ovc_done, ovd_done, ocp_done;
    logic             od_busy;

    assign ovc_cond  = |s_ovc_det;
    assign ovd_cond  = (|s_ovd_det) && !s_odinh;
    assign all_clr   = &s_ovd_clr;
    assign st_change = (state_d != state_q);

    cg_hold_timer #(.LIMIT(OVC_TICKS)) u_ovc_tmr (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .cond (ovc_cond), .restart (st_change), .count (ovc_cnt)
    );
    cg_hold_timer #(.LIMIT(OVD_TICKS)) u_ovd_tmr (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .cond (ovd_cond), .restart (st_change), .count (ovd_cnt)
    );
    cg_hold_timer #(.LIMIT(OCP_TICKS)) u_ocp_tmr (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .cond (s_ocur), .restart (st_change), .count (ocp_cnt)
    );

    assign ovc_done = (ovc_cnt == OVC_W'(OVC_TICKS));
    assign ovd_done = (ovd_cnt == OVD_W'(OVD_TICKS));
    assign ocp_done = (ocp_cnt == OCP_W'(OCP_TICKS));
    assign od_busy  = (ovd_cnt != '0);

    // per-cell overcharge latch survives only while that cell stays above recovery
    for (genvar gi = 0; gi < NCELL; gi++) begin : g_keep
        assign ocf_kept[gi] = ocf_q[gi] & s_ovc_hold[gi];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        ocf_d   = '0;
        unique case (state_q)
            CG_START: begin
                if (all_clr)       state_d = CG_NORMAL;
                else if (sync_chg) state_d = CG_ZEROV;
            end
            CG_NORMAL: begin
                if (ocp_done) begin
                    state_d = CG_OVCUR;
                end else if (ovc_done && ovd_done) begin
                    state_d = CG_BOTH;
                    ocf_d   = s_ovc_det;
                end else if (ovd_done) begin
                    state_d = CG_OVDSG;
                end else if (ovc_done) begin
                    state_d = CG_OVCHG;
                    ocf_d   = s_ovc_det;
                end
            end
            CG_OVCHG: begin
                ocf_d = ocf_kept;
                if (ovd_done) begin
                    state_d = CG_BOTH;
                end else if ((ocf_kept == '0) || s_load) begin
                    state_d = CG_NORMAL;
                    ocf_d   = '0;
                end
            end
            CG_BOTH: begin
                ocf_d = ocf_kept;
                if (!sync_chg || (ocf_kept == '0)) begin
                    state_d = CG_OVDSG;
                    ocf_d   = '0;
                end else if (all_clr) begin
                    state_d = CG_OVCHG;
                end
            end
            CG_OVDSG: begin
                if (ovc_done) begin
                    state_d = CG_BOTH;
                    ocf_d   = s_ovc_det;
                end else if (all_clr) begin
                    state_d = CG_NORMAL;
                end else if (sync_chg) begin
                    state_d = CG_ZEROV;
                end else if (!s_load) begin
                    state_d = CG_PDOWN;
                end
            end
            CG_OVCUR: begin
                if (!s_ocur) state_d = CG_NORMAL;
            end
            CG_PDOWN: begin
                if (sync_chg) state_d = all_clr ? CG_NORMAL : CG_ZEROV;
            end
            CG_ZEROV: begin
                if (all_clr)        state_d = CG_NORMAL;
                else if (!sync_chg) state_d = CG_PDOWN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CG_START;
            ocf_q   <= '0;
        end else begin
            state_q <= state_d;
            ocf_q   <= ocf_d;
        end
    end

    // outputs
    logic c_raw, d_raw, blk;
    always_comb begin
        c_raw = 1'b0;
        d_raw = 1'b0;
        bleed = '0;
        unique case (state_q)
            CG_NORMAL: begin c_raw = 1'b1; d_raw = 1'b1; end
            CG_OVCHG:  begin d_raw = 1'b1; bleed = ocf_q; end
            CG_BOTH:   bleed = ocf_q;
            CG_OVDSG:  c_raw = 1'b1;
            CG_ZEROV:  c_raw = 1'b1;
            CG_START, CG_OVCUR, CG_PDOWN: ;
        endcase
        blk      = s_ctl && (state_q != CG_PDOWN);
        chg_en   = c_raw && !blk;
        dsg_en   = d_raw && !blk;
        pwr_down = (state_q == CG_PDOWN);
    end
endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
    parameter int NCELL = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chg_en,
    input logic             dsg_en,
    input logic             pwr_down,
    input logic [NCELL-1:0] bleed,
    input logic             ctl_inhibit,
    input logic             od_inhibit,
    input logic             sync_chg,
    input logic             od_busy
);
    a_r6_bleed_blocks_charge: assert property (@(posedge clk) disable iff (!rst_n)
        (bleed != '0) |-> !chg_en);

    a_r7_pdown_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!chg_en && !dsg_en && (bleed == '0)));

    a_r8_pdown_exit_on_charger: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> $past(sync_chg));

    a_r10_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_inhibit, 2) |-> (!chg_en && !dsg_en));

    a_r11_od_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(od_inhibit, 3) |-> !od_busy);
endmodule

bind cellguard_ctrl cg_checker #(.NCELL(NCELL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chg_en      (chg_en),
    .dsg_en      (dsg_en),
    .pwr_down    (pwr_down),
    .bleed       (bleed),
    .ctl_inhibit (ctl_inhibit),
    .od_inhibit  (od_inhibit),
    .sync_chg    (sync_chg),
    .od_busy     (od_busy)
);

// File: tb/cellguard_ctrl_tb.sv
`timescale 1ns/1ps
module cellguard_ctrl_tb;
    localparam int NC  = 3;
    localparam int DIV = 4;
    localparam int OVC = 6;
    localparam int OVD = 3;
    localparam int OCP = 2;

    localparam int M_START = 0, M_NORMAL = 1, M_OVCHG = 2, M_OVDSG = 3,
                   M_BOTH = 4, M_OVCUR = 5, M_PDOWN = 6, M_ZEROV = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0] oc_det = '0, oc_hold = '0, od_det = '0, od_clr = 3'b011;
    logic chg = 1'b0, load = 1'b0, ocur = 1'b0, ctl = 1'b0, odinh = 1'b0;
    logic chg_en, dsg_en, pwr_down;
    logic [NC-1:0] bleed;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    cellguard_ctrl #(
        .NCELL(NC), .TICK_DIV(DIV), .OVC_TICKS(OVC), .OVD_TICKS(OVD), .OCP_TICKS(OCP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cell_ovc_det(oc_det), .cell_ovc_hold(oc_hold),
        .cell_ovd_det(od_det), .cell_ovd_clr(od_clr),
        .chg_seen(chg), .load_seen(load), .ocur_trip(ocur),
        .ctl_inhibit(ctl), .od_inhibit(odinh),
        .chg_en(chg_en), .dsg_en(dsg_en), .pwr_down(pwr_down), .bleed(bleed)
    );

    // behavioural reference model
    logic [16:0] in_vec, m1, m2;
    int mst, mtoc, mtod, mtop, mp, nx;
    logic [NC-1:0] mocf, nf, kept;
    logic [NC-1:0] x_ocd, x_och, x_odd, x_odc;
    logic x_chg, x_ld, x_oc, x_ctl, x_inh;
    bit tk, oc_dn, od_dn, op_dn, all_ok;

    assign in_vec = {oc_det, oc_hold, od_det, od_clr, chg, load, ocur, ctl, odinh};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; mst <= M_START; mocf <= '0;
            mtoc <= 0; mtod <= 0; mtop <= 0; mp <= 0;
        end else begin
            {x_ocd, x_och, x_odd, x_odc, x_chg, x_ld, x_oc, x_ctl, x_inh} = m2;
            tk     = (mp == DIV - 1);
            oc_dn  = (mtoc == OVC);
            od_dn  = (mtod == OVD);
            op_dn  = (mtop == OCP);
            all_ok = (x_odc == '1);
            kept   = mocf & x_och;
            nx = mst;
            nf = '0;
            case (mst)
                M_START:  if (all_ok) nx = M_NORMAL; else if (x_chg) nx = M_ZEROV;
                M_NORMAL: begin
                    if (op_dn) nx = M_OVCUR;
                    else if (oc_dn && od_dn) begin nx = M_BOTH; nf = x_ocd; end
                    else if (od_dn) nx = M_OVDSG;
                    else if (oc_dn) begin nx = M_OVCHG; nf = x_ocd; end
                end
                M_OVCHG: begin
                    nf = kept;
                    if (od_dn) nx = M_BOTH;
                    else if (kept == '0 || x_ld) begin nx = M_NORMAL; nf = '0; end
                end
                M_BOTH: begin
                    nf = kept;
                    if (!x_chg || kept == '0) begin nx = M_OVDSG; nf = '0; end
                    else if (all_ok) nx = M_OVCHG;
                end
                M_OVDSG: begin
                    if (oc_dn) begin nx = M_BOTH; nf = x_ocd; end
                    else if (all_ok) nx = M_NORMAL;
                    else if (x_chg) nx = M_ZEROV;
                    else if (!x_ld) nx = M_PDOWN;
                end
                M_OVCUR: if (!x_oc) nx = M_NORMAL;
                M_PDOWN: if (x_chg) nx = all_ok ? M_NORMAL : M_ZEROV;
                default: if (all_ok) nx = M_NORMAL; else if (!x_chg) nx = M_PDOWN;
            endcase
            if (x_ocd == '0 || nx != mst) mtoc <= 0;
            else if (tk && mtoc < OVC) mtoc <= mtoc + 1;
            if (x_odd == '0 || x_inh || nx != mst) mtod <= 0;
            else if (tk && mtod < OVD) mtod <= mtod + 1;
            if (!x_oc || nx != mst) mtop <= 0;
            else if (tk && mtop < OCP) mtop <= mtop + 1;
            mp   <= tk ? 0 : mp + 1;
            mst  <= nx;
            mocf <= nf;
            m2   <= m1;
            m1   <= in_vec;
        end
    end

    function automatic logic [5:0] model_out(int st, logic [NC-1:0] f, logic c);
        logic ce, de, pd, blk;
        logic [NC-1:0] b;
        ce = (st == M_NORMAL || st == M_OVDSG || st == M_ZEROV);
        de = (st == M_NORMAL || st == M_OVCHG);
        pd = (st == M_PDOWN);
        b  = (st == M_OVCHG || st == M_BOTH) ? f : '0;
        blk = c && !pd;
        return {ce && !blk, de && !blk, pd, b};
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [5:0] e;
            e = model_out(mst, mocf, m2[1]);
            n_chk++;
            if ({chg_en, dsg_en, pwr_down, bleed} !== e) begin
                n_err++;
                $display("FAIL %s cycle %0d: outputs act=%b exp=%b", cur_req, cyc,
                         {chg_en, dsg_en, pwr_down, bleed}, e);
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic outs(string req, int c, int d, int p, int b);
        chk(req, "chg_en", int'(chg_en), c);
        chk(req, "dsg_en", int'(dsg_en), d);
        chk(req, "pwr_down", int'(pwr_down), p);
        chk(req, "bleed", int'(bleed), b);
    endtask

    task automatic wcyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: act=%0d exp=%0d cycles", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        // R1: reset and START hold
        wcyc(3);
        outs("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        wcyc(20);
        outs("R1", 0, 0, 0, 0);
        chg = 1'b1; wcyc(5);
        outs("R1", 1, 0, 0, 0);
        od_clr = 3'b111; wcyc(5);
        cur_req = "R2";
        outs("R2", 1, 1, 0, 0);
        chg = 1'b0; wcyc(3);

        // R3: restart on dropout, then trip
        cur_req = "R3";
        oc_hold = 3'b001; oc_det = 3'b001; wcyc((OVC - 1) * DIV);
        oc_det = 3'b000; wcyc(4);
        oc_det = 3'b001; wcyc((OVC - 1) * DIV);
        oc_det = 3'b000; wcyc(3);
        chk("R3", "chg_en after restarted window", int'(chg_en), 1);
        oc_det = 3'b001; wcyc((OVC + 2) * DIV + 6);
        outs("R3", 0, 1, 0, 1);

        // R4: recovery path
        cur_req = "R4";
        oc_det = 3'b000; wcyc(5);
        outs("R4", 0, 1, 0, 1);
        oc_hold = 3'b000; wcyc(5);
        outs("R4", 1, 1, 0, 0);

        // R6 / R5: two cells, partial recovery, load release
        cur_req = "R6";
        oc_hold = 3'b101; oc_det = 3'b101; wcyc((OVC + 2) * DIV + 6);
        outs("R6", 0, 1, 0, 5);
        oc_det = 3'b000; oc_hold = 3'b100; wcyc(5);
        outs("R6", 0, 1, 0, 4);
        cur_req = "R5";
        load = 1'b1; wcyc(5);
        outs("R5", 1, 1, 0, 0);
        oc_hold = 3'b000; wcyc(3);

        // R7: overdischarge then power-down
        cur_req = "R7";
        od_det = 3'b010; od_clr = 3'b101; wcyc((OVD + 2) * DIV + 6);
        outs("R7", 1, 0, 0, 0);
        load = 1'b0; wcyc(5);
        outs("R7", 0, 0, 1, 0);

        // R10 in power-down, R8 exit
        cur_req = "R10";
        ctl = 1'b1; wcyc(6);
        chk("R10", "pwr_down held", int'(pwr_down), 1);
        chg = 1'b1; wcyc(5);
        outs("R10", 0, 0, 0, 0);
        cur_req = "R8";
        ctl = 1'b0; wcyc(5);
        outs("R8", 1, 0, 0, 0);
        od_det = 3'b000; od_clr = 3'b111; wcyc(5);
        outs("R8", 1, 1, 0, 0);

        // R9: both conditions
        cur_req = "R9";
        oc_hold = 3'b001; oc_det = 3'b001; wcyc((OVC + 2) * DIV + 6);
        outs("R9", 0, 1, 0, 1);
        od_det = 3'b010; od_clr = 3'b101; wcyc((OVD + 2) * DIV + 6);
        outs("R9", 0, 0, 0, 1);
        chg = 1'b0; load = 1'b1; oc_det = 3'b000; wcyc(5);
        outs("R9", 1, 0, 0, 0);
        oc_hold = 3'b000; od_det = 3'b000; od_clr = 3'b111; wcyc(5);
        outs("R9", 1, 1, 0, 0);

        // R10 in normal
        cur_req = "R10";
        ctl = 1'b1; wcyc(4);
        outs("R10", 0, 0, 0, 0);
        ctl = 1'b0; wcyc(4);
        outs("R10", 1, 1, 0, 0);

        // R11: overdischarge inhibit
        cur_req = "R11";
        odinh = 1'b1; wcyc(3);
        od_det = 3'b111; od_clr = 3'b000; wcyc((OVD + 4) * DIV + 6);
        outs("R11", 1, 1, 0, 0);
        od_det = 3'b000; od_clr = 3'b111; wcyc(5);
        odinh = 1'b0; wcyc(3);

        // R12: overcurrent
        cur_req = "R12";
        ocur = 1'b1; wcyc((OCP - 1) * DIV);
        ocur = 1'b0; wcyc(5);
        outs("R12", 1, 1, 0, 0);
        ocur = 1'b1; wcyc((OCP + 2) * DIV + 6);
        outs("R12", 0, 0, 0, 0);
        ocur = 1'b0; wcyc(5);
        outs("R12", 1, 1, 0, 0);

        wcyc(4);
        finish_run();
    end
endmodule